// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps events on an external pin. A 16-bit free-running count advances once per four system clocks behind a fixed prescaler. The pin passes through a two-flop synchroniser and an edge detector whose polarity comes from a control bit. On each qualifying edge the count is copied into a 16-bit capture holder, and a capture flag is raised. Software sees the holder as two byte registers on a small read/write bus. Because of the synchroniser, the stored stamp is one count ahead of the count that was live when the pin moved.

Two small state machines do the bus-side work. The flag machine has the states FLAG_IDLE, FLAG_UP and FLAG_ARMED. It moves FLAG_IDLE→FLAG_UP on a capture. It moves FLAG_UP→FLAG_ARMED on a status read. It returns FLAG_ARMED→FLAG_IDLE on a low-byte read that does not meet a capture. A capture in any state sends it to FLAG_UP. The byte-pair machine has the states PAIR_OPEN and PAIR_HELD. It moves PAIR_OPEN→PAIR_HELD on a high-byte read, which also snapshots the low byte. It moves PAIR_HELD→PAIR_OPEN on a low-byte read. A further high-byte read in PAIR_HELD refreshes the snapshot.

Register offsets:
- 0x12: control. Bit 0 is the edge select; the register reads back all 8 bits.
- 0x13: status. Bit 7 is the capture flag; the other bits read 0.
- 0x14: capture high byte, read-only.
- 0x15: capture low byte, read-only.
- Any other offset reads 0.

Top module: `tcap_unit`

## Requirements
- R1: After reset the count is 0xFFFC. It rises by one on every fourth clock edge after reset release, so after edge k it is 0xFFFC + k/4 modulo 2^16. It wraps from 0xFFFF to 0x0000.
- R2: Control bit 0 at 0x12 picks the qualifying pin edge: 1 is rising, 0 is falling. An edge of the other polarity leaves the flag and both capture bytes unchanged.
- R3: Suppose the pin changes between clock edge E0 and the next edge. The capture bytes then hold (count after E0) + 1, readable from the third edge after E0 onward. The high byte is read at 0x14 and the low byte at 0x15.
- R4: Every qualifying edge overwrites the capture bytes, even while the flag is already set. The bytes always show the most recent stamp.
- R5: A capture sets status bit 7 at 0x13. Status reads 0x80 with the flag set and 0x00 with it clear.
- R6: The flag clears only when a read of 0x15 follows a read of 0x13 made while the flag was set. A read of 0x15 with no such earlier status read leaves the flag set.
- R7: If a capture lands in the same cycle as a clearing read of 0x15, the flag stays set. That read returns the low byte held before the capture.
- R8: A read of 0x14 freezes the low byte. The next read of 0x15 returns the low half of the same stamp, even if a capture lands between the two reads.
- R9: Writes to 0x14 and 0x15 change nothing. A reset leaves the capture bytes unchanged.
- R10: After reset, the control register reads 0x00 (falling edge selected) and status reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | External event input, asynchronous |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_rd | input | 1 | Read strobe; side effects occur at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |

## Verification
Two pairs of functions can coincide. A capture write can fall in the same clock as the low-byte read that would clear the flag. A capture can also arrive between the high-byte and low-byte reads of a pair. For the first pair, the bench arms the flag with a status read. It then moves the pin and starts the 0x15 read two edges later, so that the read's edge is the one that stores the new stamp. It expects the old low byte on the bus and the flag still set afterwards. For the second pair, it reads 0x14, triggers a fresh capture, and expects 0x15 to return the low half of the earlier stamp. The next full pair must then show the new stamp.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
    localparam int unsigned BUS_AW      = 8;
    localparam int unsigned BUS_DW      = 8;
    localparam int unsigned STAMP_W     = 16;
    localparam int unsigned PRESC_DIV   = 4;
    localparam int unsigned SYNC_STAGES = 2;

    localparam logic [STAMP_W-1:0] STAMP_RESET = 16'hFFFC;

    localparam logic [BUS_AW-1:0] OFS_CTRL = 8'h12;
    localparam logic [BUS_AW-1:0] OFS_STAT = 8'h13;
    localparam logic [BUS_AW-1:0] OFS_CAPH = 8'h14;
    localparam logic [BUS_AW-1:0] OFS_CAPL = 8'h15;

    typedef enum logic [1:0] {
        FLAG_IDLE  = 2'd0,
        FLAG_UP    = 2'd1,
        FLAG_ARMED = 2'd2
    } flag_state_t;

    typedef enum logic {
        PAIR_OPEN = 1'b0,
        PAIR_HELD = 1'b1
    } pair_state_t;
endpackage

// File: rtl/tcap_counter.sv
module tcap_counter #(
    parameter int unsigned          CNT_W   = tcap_pkg::STAMP_W,
    parameter int unsigned          DIV     = tcap_pkg::PRESC_DIV,
    parameter logic [CNT_W-1:0]     RST_VAL = tcap_pkg::STAMP_RESET
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] presc;
    logic          tick;

    assign tick = (presc == PW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc <= '0;
            count <= RST_VAL;
        end else begin
            presc <= tick ? '0 : presc + PW'(1);
            if (tick) begin
                count <= count + CNT_W'(1);
            end
        end
    end

    // R1: roll over from all ones to zero
    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == '1) |=> (count == '0));

    // R1: no movement between prescaler ticks
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
endmodule

// File: rtl/tcap_edge.sv
module tcap_edge #(
    parameter int unsigned STAGES = tcap_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic hit
);
    logic [STAGES:0] sh;
    logic            newer;
    logic            older;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], pin};
        end
    end

    assign newer = sh[STAGES-1];
    assign older = sh[STAGES];
    assign hit   = rise_sel ? (newer & ~older) : (~newer & older);

    // R2: a rising qualifier cannot repeat on the very next cycle
    assert_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && rise_sel) |=> !(newer && !older));
endmodule

// File: rtl/tcap_regs.sv
module tcap_regs
    import tcap_pkg::*;
#(
    parameter int unsigned AW    = BUS_AW,
    parameter int unsigned DW    = BUS_DW,
    parameter int unsigned CNT_W = STAMP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             wr,
    input  logic             rd,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic             cap_evt,
    input  logic [CNT_W-1:0] cap_val,
    output logic             edge_sel
);
    localparam int unsigned HALF = CNT_W / 2;

    flag_state_t fstate, fnext;
    pair_state_t pstate, pnext;

    logic [DW-1:0]    ctrl_q;
    logic [CNT_W-1:0] cap_q;
    logic [HALF-1:0]  lo_buf;
    logic             flag;
    logic             stat_rd, hi_rd, lo_rd;

    assign stat_rd  = rd && (addr == AW'(OFS_STAT));
    assign hi_rd    = rd && (addr == AW'(OFS_CAPH));
    assign lo_rd    = rd && (addr == AW'(OFS_CAPL));
    assign edge_sel = ctrl_q[0];

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr && addr == AW'(OFS_CTRL)) begin
            ctrl_q <= wdata;
        end
    end

    // capture holder and low-byte snapshot: not touched by reset
    always_ff @(posedge clk) begin
        if (cap_evt) begin
            cap_q <= cap_val;
        end
        if (hi_rd) begin
            lo_buf <= cap_q[HALF-1:0];
        end
    end

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fstate <= FLAG_IDLE;
            pstate <= PAIR_OPEN;
        end else begin
            fstate <= fnext;
            pstate <= pnext;
        end
    end

    // next-state logic
    always_comb begin
        fnext = fstate;
        unique case (fstate)
            FLAG_IDLE:  if (cap_evt) fnext = FLAG_UP;
            FLAG_UP:    if (cap_evt) fnext = FLAG_UP;
                        else if (stat_rd) fnext = FLAG_ARMED;
            FLAG_ARMED: if (cap_evt) fnext = FLAG_UP;
                        else if (lo_rd) fnext = FLAG_IDLE;
            default:    fnext = FLAG_IDLE;
        endcase

        pnext = pstate;
        unique case (pstate)
            PAIR_OPEN: if (hi_rd) pnext = PAIR_HELD;
            PAIR_HELD: if (lo_rd && !hi_rd) pnext = PAIR_OPEN;
            default:   pnext = PAIR_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        flag = (fstate != FLAG_IDLE);
        unique case (addr)
            AW'(OFS_CTRL): rdata = ctrl_q;
            AW'(OFS_STAT): rdata = {flag, {(DW-1){1'b0}}};
            AW'(OFS_CAPH): rdata = cap_q[CNT_W-1:HALF];
            AW'(OFS_CAPL): rdata = (pstate == PAIR_HELD) ? lo_buf : cap_q[HALF-1:0];
            default:       rdata = '0;
        endcase
    end

    // R5: a capture always leaves the flag raised
    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> flag);

    // R7: capture beats a clearing read in the same cycle
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && fstate == FLAG_ARMED && lo_rd) |=> (fstate == FLAG_UP));

    // R6: an armed low-byte read without a capture drops the flag
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fstate == FLAG_ARMED && lo_rd && !cap_evt) |=> !flag);

    // R4: every capture stores the presented stamp
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_q == $past(cap_val)));

    // R9: without a capture the holder does not move, whatever the bus does
    assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(cap_q));

    // R8: the snapshot is frozen while a pair is held
    assert_pair_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PAIR_HELD && !hi_rd) |=> $stable(lo_buf));
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
    import tcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_pin,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata
);
    logic [STAMP_W-1:0] count;
    logic [STAMP_W-1:0] cdel [SYNC_STAGES];
    logic [STAMP_W-1:0] stamp;
    logic               hit;
    logic               edge_sel;

    tcap_counter #(
        .CNT_W  (STAMP_W),
        .DIV    (PRESC_DIV),
        .RST_VAL(STAMP_RESET)
    ) u_counter (
        .clk  (clk),
        .rst_n(rst_n),
        .count(count)
    );

    tcap_edge #(
        .STAGES(SYNC_STAGES)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (cap_pin),
        .rise_sel(edge_sel),
        .hit     (hit)
    );

    // count delayed alongside the synchroniser so the stamp meets the +1 rule
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_cdel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cdel[g] <= '0;
            end else if (g == 0) begin
                cdel[g] <= count;
            end else begin
                cdel[g] <= cdel[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign stamp = cdel[SYNC_STAGES-1] + STAMP_W'(1);

    tcap_regs #(
        .AW   (BUS_AW),
        .DW   (BUS_DW),
        .CNT_W(STAMP_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .cap_evt (hit),
        .cap_val (stamp),
        .edge_sel(edge_sel)
    );
endmodule

// File: tb/tcap_unit_bench.sv
module tcap_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cap_pin = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic done = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    tcap_unit u_tcap_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_pin  (cap_pin),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    always #2 clk = ~clk;

    // edges since reset release (R1 timebase)
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // monitor: compare every read against the scoreboard
    always @(negedge clk) begin
        if (bus_rd && rst_n) begin
            exp_t it;
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL %s: unexpected read, actual %02h expected none", "scoreboard", bus_rdata);
            end else begin
                it = exp_q.pop_front();
                if (bus_rdata !== it.val) begin
                    n_bad++;
                    $display("FAIL %s: addr %02h actual %02h expected %02h", it.tag, bus_addr, bus_rdata, it.val);
                end
            end
        end
    end

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    // driver: push the expectation, then issue the read
    task automatic chk(input logic [7:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        it.val = e; it.tag = tag;
        exp_q.push_back(it);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    function automatic logic [15:0] stamp_now();
        return 16'(32'h0000FFFC + 32'(cyc / 4) + 1);
    endfunction

    // qualifying edge: R3 expected stamp computed at the drive point
    task automatic edge_to(input logic v, output logic [15:0] e);
        @(posedge clk); #1;
        e = stamp_now();
        cap_pin = v;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic toggle(input logic v);
        @(posedge clk); #1;
        cap_pin = v;
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        logic [15:0] c, a, b;
        exp_t it;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        chk(8'h12, 8'h00, "R10 ctrl after reset");
        chk(8'h13, 8'h00, "R10 status after reset");

        wr(8'h12, 8'h01);
        edge_to(1'b1, c);
        chk(8'h14, c[15:8], "R3 high byte");
        chk(8'h15, c[7:0],  "R3 low byte");
        chk(8'h13, 8'h80,   "R5 flag set");
        chk(8'h15, c[7:0],  "R6 clearing read");
        chk(8'h13, 8'h00,   "R6 flag cleared");

        toggle(1'b0);
        chk(8'h13, 8'h00,   "R2 wrong edge flag");
        chk(8'h15, c[7:0],  "R2 wrong edge low byte");

        edge_to(1'b1, c);
        chk(8'h15, c[7:0],  "R6 low read unarmed");
        chk(8'h13, 8'h80,   "R6 flag kept");
        chk(8'h15, c[7:0],  "R6 armed low read");
        chk(8'h13, 8'h00,   "R6 flag cleared again");

        wr(8'h12, 8'h00);
        edge_to(1'b0, a);
        toggle(1'b1);
        repeat (5) @(posedge clk);
        edge_to(1'b0, b);
        if (a == b) begin
            n_cmp++; n_bad++;
            $display("FAIL R4: actual %04h expected differing stamps", a);
        end
        chk(8'h14, b[15:8], "R4 latest high");
        chk(8'h15, b[7:0],  "R4 latest low");
        chk(8'h13, 8'h80,   "R4 flag");

        chk(8'h14, b[15:8], "R8 high opens pair");
        toggle(1'b1);
        edge_to(1'b0, c);
        chk(8'h15, b[7:0],  "R8 frozen low");
        chk(8'h14, c[15:8], "R8 new high");
        chk(8'h15, c[7:0],  "R8 new low");

        // R7: arm, then collide a clearing read with the capture write
        toggle(1'b1);
        chk(8'h13, 8'h80, "R7 arm");
        @(posedge clk); #1;
        a = stamp_now();
        cap_pin = 1'b0;
        @(posedge clk);
        @(posedge clk); #1;
        it.val = c[7:0]; it.tag = "R7 read in capture cycle";
        exp_q.push_back(it);
        bus_addr = 8'h15; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        chk(8'h13, 8'h80,   "R7 flag survives");
        chk(8'h15, a[7:0],  "R7 stored stamp");
        chk(8'h13, 8'h00,   "R6 normal clear");

        wr(8'h14, 8'h55);
        wr(8'h15, 8'hAA);
        chk(8'h14, a[15:8], "R9 write ignored high");
        chk(8'h15, a[7:0],  "R9 write ignored low");
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        chk(8'h14, a[15:8], "R9 high kept over reset");
        chk(8'h15, a[7:0],  "R9 low kept over reset");
        chk(8'h12, 8'h00,   "R10 ctrl after second reset");
        chk(8'h13, 8'h00,   "R10 status after second reset");

        toggle(1'b1);
        while (cyc < 16) begin @(posedge clk); #1; end
        edge_to(1'b0, c);
        chk(8'h14, 8'h00, "R1 wrapped high");
        chk(8'h15, 8'h01, "R1 wrapped low");
        toggle(1'b1);
        while (cyc < 34) begin @(posedge clk); #1; end
        edge_to(1'b0, c);
        chk(8'h14, 8'h00, "R1 step high");
        chk(8'h15, 8'h05, "R1 step low");

        repeat (2) @(posedge clk);
        done = 1'b1;
        report();
    end
endmodule